// File: doc/BRIEF.md
# Registered Dual-Clock Embedded RAM

A 2,048-bit embedded memory with one write port and one read port. The shape is fixed at compile time through `DATA_W` (16, 8, 4, 2 or 1 bits per word), which sets the depth to 2048 / `DATA_W` words. The address width then follows as log2 of that depth.

Every request input is captured in a register on the input clock, but only in cycles where the input clock enable is high. These inputs are write data, write address, write enable, read address and read enable. A write strobe is derived from the registered write enable and commits the registered data at the next enabled input edge.

The read word is taken from the registered read address. It passes to the port through an output register that sits on its own output clock and has its own enable. When the registered read enable is low, a hold register keeps the last read word. The active-low asynchronous clear zeroes every register but leaves the stored words alone.

Top module: `dual_clk_ram`

## Requirements
- R1: With `DATA_W` = 8 (the default) the array holds 256 distinct 8-bit words, addressed by bits [7:0] of the address ports. Every one of the 256 locations holds its own value independently.
- R2: Input registers load only on an input clock edge with `in_ce_i` high. While `in_ce_i` is low, changes on the request inputs have no effect: no write occurs and the read address does not move.
- R3: A request captured with write enable high writes its data to its address at the next input edge with `in_ce_i` high. No other location changes.
- R4: A read request captured at an input edge with read enable high is visible on `rd_data_o` after the next output clock edge with `out_ce_i` high.
- R5: `rd_data_o` changes only at an output clock edge with `out_ce_i` high. Otherwise it holds.
- R6: While the registered read enable is low, the read word keeps the value of the last enabled read, or zero after a clear.
- R7: A read and a write to the same address captured at the same edge return the contents from before that write.
- R8: Driving `rst_ni` low clears the input, hold and output registers at once, so `rd_data_o` reads 0 without a clock edge. The stored words are kept and can be read after the clear is released.
- R9: Address bits at and above `ADDR_W` and write-data bits at and above `DATA_W` are ignored. Bits of `rd_data_o` at and above `DATA_W` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk_i | input | 1 | Input-stage clock |
| out_clk_i | input | 1 | Output-register clock |
| rst_ni | input | 1 | Active-low asynchronous clear of all registers |
| in_ce_i | input | 1 | Input-stage clock enable |
| out_ce_i | input | 1 | Output-register clock enable |
| wr_en_i | input | 1 | Write request |
| wr_addr_i | input | 11 | Write address (low ADDR_W bits used) |
| wr_data_i | input | 16 | Write data (low DATA_W bits used) |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | 11 | Read address (low ADDR_W bits used) |
| rd_data_o | output | 16 | Registered read data, upper bits zero |

## Verification
If a write strobe lands on the wrong edge or the wrong address, the fault shows as a wrong word at the port on the first later read of the damaged location. That read can come many cycles after the bad write. For this reason the whole array is filled and then swept.

Faults in enable gating, the read hold or the output register show on `rd_data_o` within one or two clock edges of the stimulus. The per-cycle model comparison catches them at that edge.

A clear that also wiped the array, or failed to zero the registers, shows as soon as the clear is asserted or on the first read-back after it.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int unsigned TOTAL_BITS = 2048;
  localparam int unsigned MAX_DW     = 16;
  localparam int unsigned PORT_AW    = 11;

  function automatic bit shape_ok(input int unsigned dw);
    return dw == 1 || dw == 2 || dw == 4 || dw == 8 || dw == 16;
  endfunction
endpackage

// File: rtl/dcr_in_stage.sv
module dcr_in_stage
  import dcr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ce_i,
  input  logic               wr_en_i,
  input  logic [PORT_AW-1:0] wr_addr_i,
  input  logic [MAX_DW-1:0]  wr_data_i,
  input  logic               rd_en_i,
  input  logic [PORT_AW-1:0] rd_addr_i,
  output logic               we_q_o,
  output logic [ADDR_W-1:0]  wa_q_o,
  output logic [DATA_W-1:0]  wd_q_o,
  output logic               re_q_o,
  output logic [ADDR_W-1:0]  ra_q_o
);
  // upper bits are dropped by the slices below
  logic unused_hi;
  assign unused_hi = ^{wr_addr_i, wr_data_i, rd_addr_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q_o <= 1'b0;
      wa_q_o <= '0;
      wd_q_o <= '0;
      re_q_o <= 1'b0;
      ra_q_o <= '0;
    end else if (ce_i) begin
      we_q_o <= wr_en_i;
      wa_q_o <= wr_addr_i[ADDR_W-1:0];
      wd_q_o <= wr_data_i[DATA_W-1:0];
      re_q_o <= rd_en_i;
      ra_q_o <= rd_addr_i[ADDR_W-1:0];
    end
  end

  a_r2_in_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> $stable({we_q_o, wa_q_o, wd_q_o, re_q_o, ra_q_o}));
endmodule

// File: rtl/dcr_wr_pulse.sv
module dcr_wr_pulse (
  input  logic we_q_i,
  input  logic ce_i,
  output logic wr_strobe_o
);
  // commit the captured write at the next enabled input edge
  assign wr_strobe_o = we_q_i & ce_i;
endmodule

// File: rtl/dcr_array.sv
module dcr_array #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 256,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              wr_strobe_i,
  input  logic [ADDR_W-1:0] wa_i,
  input  logic [DATA_W-1:0] wd_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] ra_i,
  output logic [DATA_W-1:0] rd_word_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] hold_q;

  // array has no reset: clear touches registers only
  always_ff @(posedge clk_i) begin
    if (wr_strobe_i) mem_q[wa_i] <= wd_i;
  end

  // combinational read sees pre-edge contents: read-before-write
  assign rd_word_o = re_i ? mem_q[ra_i] : hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hold_q <= '0;
    else if (ce_i) hold_q <= rd_word_o;
  end

  a_r3_no_stray_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_strobe_i |=> mem_q[$past(wa_i)] === $past(mem_q[wa_i]));

  a_r6_read_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!re_i && $stable(re_i)) |=> (!re_i -> $stable(rd_word_o)));
endmodule

// File: rtl/dcr_out_stage.sv
module dcr_out_stage #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ce_i) q_o <= d_i;
  end

  a_r5_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> $stable(q_o));
endmodule

// File: rtl/dual_clk_ram.sv
module dual_clk_ram
  import dcr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic               in_clk_i,
  input  logic               out_clk_i,
  input  logic               rst_ni,
  input  logic               in_ce_i,
  input  logic               out_ce_i,
  input  logic               wr_en_i,
  input  logic [PORT_AW-1:0] wr_addr_i,
  input  logic [MAX_DW-1:0]  wr_data_i,
  input  logic               rd_en_i,
  input  logic [PORT_AW-1:0] rd_addr_i,
  output logic [MAX_DW-1:0]  rd_data_o
);
  localparam int unsigned DEPTH  = TOTAL_BITS / DATA_W;
  localparam int unsigned ADDR_W = $clog2(DEPTH);

  if (!shape_ok(DATA_W)) begin : g_bad_shape
    $error("dual_clk_ram: unsupported DATA_W");
  end

  logic              we_q, re_q, wr_strobe;
  logic [ADDR_W-1:0] wa_q, ra_q;
  logic [DATA_W-1:0] wd_q, rd_word, out_q;

  dcr_in_stage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_in (
    .clk_i(in_clk_i), .rst_ni(rst_ni), .ce_i(in_ce_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .we_q_o(we_q), .wa_q_o(wa_q), .wd_q_o(wd_q), .re_q_o(re_q), .ra_q_o(ra_q)
  );

  dcr_wr_pulse u_pulse (
    .we_q_i(we_q), .ce_i(in_ce_i), .wr_strobe_o(wr_strobe)
  );

  dcr_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_array (
    .clk_i(in_clk_i), .rst_ni(rst_ni), .ce_i(in_ce_i),
    .wr_strobe_i(wr_strobe), .wa_i(wa_q), .wd_i(wd_q),
    .re_i(re_q), .ra_i(ra_q), .rd_word_o(rd_word)
  );

  dcr_out_stage #(.WIDTH(DATA_W)) u_out (
    .clk_i(out_clk_i), .rst_ni(rst_ni), .ce_i(out_ce_i),
    .d_i(rd_word), .q_o(out_q)
  );

  if (DATA_W < MAX_DW) begin : g_pad
    assign rd_data_o = {{(MAX_DW-DATA_W){1'b0}}, out_q};
  end else begin : g_full
    assign rd_data_o = out_q;
  end

  a_r4_read_reaches_port: assert property (@(posedge out_clk_i) disable iff (!rst_ni)
    (out_ce_i && re_q) |=> rd_data_o[DATA_W-1:0] == $past(u_array.mem_q[ra_q]));
endmodule

// File: tb/dual_clk_ram_bench.sv
module dual_clk_ram_bench;
  localparam int DW = 8;
  localparam int DEPTH = 2048 / DW;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ice = 1'b0, oce = 1'b0, we = 1'b0, re = 1'b0;
  logic [10:0] wa = '0, ra = '0;
  logic [15:0] wd = '0;
  logic [15:0] rdo;

  always #10 clk = ~clk;

  dual_clk_ram #(.DATA_W(DW)) u_dual_clk_ram (
    .in_clk_i(clk), .out_clk_i(clk), .rst_ni(rst_n),
    .in_ce_i(ice), .out_ce_i(oce),
    .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
    .rd_en_i(re), .rd_addr_i(ra), .rd_data_o(rdo)
  );

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit compare_on = 1'b0;

  // behavioural reference
  int m_mem [DEPTH];
  int m_we, m_re, m_wa, m_ra, m_wd, m_hold, m_out;

  always @(posedge clk or negedge rst_n) begin
    int rdw;
    if (!rst_n) begin
      m_we = 0; m_re = 0; m_wa = 0; m_ra = 0; m_wd = 0; m_hold = 0; m_out = 0;
    end else begin
      rdw = m_re ? m_mem[m_ra] : m_hold;
      if (oce) m_out = rdw;
      if (ice) begin
        if (m_we) m_mem[m_wa] = m_wd;
        m_hold = rdw;
        m_we = we; m_re = re;
        m_wa = wa % DEPTH; m_ra = ra % DEPTH;
        m_wd = wd % (1 << DW);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: rd_data_o=%0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (compare_on) check(cur_req, int'(rdo), m_out);

  task automatic step(input bit w, input int a_w, input int d_w,
                      input bit r, input int a_r, input bit ic, input bit oc);
    we = w; wa = 11'(a_w); wd = 16'(d_w); re = r; ra = 11'(a_r); ice = ic; oce = oc;
    @(negedge clk);
  endtask

  logic [15:0] lfsr = 16'hACE1;
  function automatic logic [15:0] nxt(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R8", int'(rdo), 0);  // reset state
    rst_n = 1'b1;
    @(negedge clk);
    compare_on = 1'b1;

    // R1 fill every location, then sweep it back
    cur_req = "R1";
    for (int a = 0; a < DEPTH; a++) step(1, a, (a * 37 + 11) & 8'hFF, 0, 0, 1, 1);
    step(0, 0, 0, 0, 0, 1, 1);
    for (int a = 0; a < DEPTH; a++) step(0, 0, 0, 1, a, 1, 1);

    // R4 latency: one capture edge, then one output edge
    cur_req = "R4";
    step(1, 20, 8'h3C, 0, 0, 1, 1);
    step(0, 0, 0, 1, 20, 1, 1);
    step(0, 0, 0, 0, 0, 1, 1);
    check("R4", int'(rdo), 8'h3C);

    // R7 read and write same address in one capture
    cur_req = "R7";
    step(1, 33, 8'hE7, 1, 33, 1, 1);
    step(0, 0, 0, 0, 0, 1, 1);
    check("R7", int'(rdo), (33 * 37 + 11) & 8'hFF);
    step(0, 0, 0, 1, 33, 1, 1);
    step(0, 0, 0, 0, 0, 1, 1);
    check("R3", int'(rdo), 8'hE7);

    // R2 input enable low: scrambled inputs do nothing
    cur_req = "R2";
    step(0, 0, 0, 1, 50, 1, 1);
    for (int i = 0; i < 40; i++) begin
      lfsr = nxt(lfsr);
      step(lfsr[0], lfsr[8:1], lfsr[15:8], lfsr[1], lfsr[10:3], 0, 1);
    end
    check("R2", int'(rdo), (50 * 37 + 11) & 8'hFF);

    // R5 output enable low
    cur_req = "R5";
    for (int i = 0; i < 30; i++) begin
      lfsr = nxt(lfsr);
      step(0, 0, 0, 1, lfsr[7:0], 1, 0);
    end

    // R6 read enable low holds last word
    cur_req = "R6";
    step(0, 0, 0, 1, 77, 1, 1);
    for (int i = 0; i < 20; i++) begin
      lfsr = nxt(lfsr);
      step(0, 0, 0, 0, lfsr[7:0], 1, 1);
    end
    check("R6", int'(rdo), (77 * 37 + 11) & 8'hFF);

    // R9 upper address and data bits
    cur_req = "R9";
    step(1, 11'h400 | 5, 16'hAB96, 0, 0, 1, 1);
    step(0, 0, 0, 1, 11'h200 | 5, 1, 1);
    step(0, 0, 0, 0, 0, 1, 1);
    check("R9", int'(rdo), 16'h0096);

    // mixed random traffic, all enables toggling
    cur_req = "R3";
    for (int i = 0; i < 2000; i++) begin
      lfsr = nxt(lfsr);
      step(lfsr[0], lfsr[9:2], lfsr[15:4], lfsr[3], lfsr[13:6], lfsr[1] | lfsr[5], lfsr[2] | lfsr[7]);
    end

    // R8 asynchronous clear mid-run keeps array
    cur_req = "R8";
    step(1, 90, 8'h5D, 0, 0, 1, 1);
    step(0, 0, 0, 1, 90, 1, 1);
    step(0, 0, 0, 1, 90, 1, 1);
    check("R8", int'(rdo), 8'h5D);
    compare_on = 1'b0;
    #5 rst_n = 1'b0;
    #1 check("R8", int'(rdo), 0);
    @(negedge clk);
    rst_n = 1'b1;
    compare_on = 1'b1;
    step(0, 0, 0, 1, 90, 1, 1);
    step(0, 0, 0, 0, 0, 1, 1);
    check("R8", int'(rdo), 8'h5D);

    compare_on = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule